// File: doc/BRIEF.md
# ATA Register Window Unlock Sequencer

This block sits between a host register bus and the command-block register file of an IDE channel. In normal operation every access goes through to a shadow copy of the task-file registers. The block also watches the stream of host accesses for a short key sequence. The sequence is two 16-bit reads at offset 1, then an 8-bit write of 0x03 at offset 2. When the key completes, the eight command-block offsets stop reaching the task file. They reach a small hidden bank of configuration registers instead.

While this window is open, 8-bit accesses read and write the configuration bank. That bank holds the read and write cycle timing bytes, a channel control register, a read-only strap register and a miscellaneous register. An 8-bit write of 0x83 at offset 2 closes the window and brings back the task-file mapping. The timing block downstream uses the configuration contents, which are driven out as plain ports.

Top module: `ata_cfg_window`

## Requirements
- R1: After reset the window is closed, chan_en_o is 0 (control reads 0x11), both timing outputs are 0x00 and misc_o is 0.
- R2: A 16-bit read at offset 1, a second 16-bit read at offset 1, then an 8-bit write with data 0x03 at offset 2 open the window. win_open_o is high from the clock edge that accepts that write. Cycles with no strobe between the steps do not break the sequence.
- R3: An access that is not the next expected key step sends the detector back to idle. If that access is a 16-bit read at offset 1, it counts as the first step. A mismatched write still reaches the task file.
- R4: The two key reads return task-file data. The key write of 0x03 is absorbed: it changes neither the task file nor the configuration bank.
- R5: While the window is open, 8-bit accesses reach the configuration bank and never the task file. 16-bit reads return 0 and 16-bit writes are ignored.
- R6: An 8-bit write of 0x83 at offset 2 while the window is open closes it from that clock edge. The write itself is absorbed. Any other value written at offset 2 leaves the window open.
- R7: Offset 0 (read timing) and offset 1 (write timing) are 8-bit read/write registers, driven on rd_timing_o and wr_timing_o. They keep their values after the window closes.
- R8: Offset 3 is the control register. Writing 0x95 sets chan_en_o, writing 0x11 clears it, and any other value is ignored. It reads back 0x95 when the channel is enabled and 0x11 when it is disabled.
- R9: Offset 5 is read-only. Bit 0 returns strap_slow_i (0 = 33 MHz bus, 1 = 25 MHz bus) and the other bits read 0. Writes to it have no effect.
- R10: Offset 6 stores only the bits of the written byte under mask 0x7F. It reads back with bit 7 at 0 and is driven on misc_o.
- R11: With the window closed, a 16-bit write at an offset stores the whole word. An 8-bit write stores the low byte and leaves the high byte as it was. A 16-bit read returns the whole word, and an 8-bit read returns the low byte zero-extended.
- R12: rdata_o is 0 in any cycle where rd_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Command-block register offset |
| wide_i | input | 1 | Access size: 1 = 16-bit, 0 = 8-bit |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid in the cycle rd_i is high |
| strap_slow_i | input | 1 | Bus speed strap: 0 = 33 MHz, 1 = 25 MHz |
| win_open_o | output | 1 | Configuration window open |
| rd_timing_o | output | 8 | Read-cycle timing byte |
| wr_timing_o | output | 8 | Write-cycle timing byte |
| chan_en_o | output | 1 | Channel enabled by control register |
| misc_o | output | 7 | Miscellaneous configuration bits |

## Verification
The hardest case to reach from the ports is a mismatch that is itself a valid first step: a third 16-bit read at offset 1 while the detector already waits for the key write. The stimulus issues three such reads and then the key write, and the window must stay shut. It then issues four reads and the key write, and the window must open. The checks on the task file go through the normal read path after the window closes. They show that the key writes were absorbed and that the configuration writes never touched the task file.

// File: rtl/ata_win_pkg.sv
package ata_win_pkg;
  localparam int CFG_W  = 8;
  localparam int MISC_W = 7;

  localparam logic [CFG_W-1:0] KEY_OPEN  = 8'h03;
  localparam logic [CFG_W-1:0] KEY_CLOSE = 8'h83;
  localparam logic [CFG_W-1:0] CTL_ON    = 8'h95;
  localparam logic [CFG_W-1:0] CTL_OFF   = 8'h11;
  localparam logic [CFG_W-1:0] MISC_MASK = 8'h7F;

  localparam int OFS_PROBE = 1;
  localparam int OFS_KEY   = 2;
  localparam int OFS_RDT   = 0;
  localparam int OFS_WRT   = 1;
  localparam int OFS_CTL   = 3;
  localparam int OFS_STRAP = 5;
  localparam int OFS_MISC  = 6;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ONE  = 2'd1,
    ST_TWO  = 2'd2
  } unlock_st_e;
endpackage

// File: rtl/ata_win_unlock.sv
module ata_win_unlock
  import ata_win_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              wide_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CFG_W-1:0]  wbyte_i,
  output logic              open_o,
  output logic              key_hit_o
);
  unlock_st_e st_q, st_d;
  logic open_q, open_d;
  logic acc, probe, key_wr, open_hit, close_hit;

  assign acc      = rd_i | wr_i;
  assign probe    = rd_i && !wr_i && wide_i && (addr_i == ADDR_W'(OFS_PROBE));
  assign key_wr   = wr_i && !rd_i && !wide_i && (addr_i == ADDR_W'(OFS_KEY));
  assign open_hit = !open_q && (st_q == ST_TWO) && key_wr && (wbyte_i == KEY_OPEN);
  assign close_hit = open_q && key_wr && (wbyte_i == KEY_CLOSE);

  always_comb begin
    st_d   = st_q;
    open_d = open_q;
    if (open_q) begin
      st_d = ST_IDLE;
      if (close_hit) open_d = 1'b0;
    end else if (acc) begin
      unique case (st_q)
        ST_IDLE: st_d = probe ? ST_ONE : ST_IDLE;
        ST_ONE:  st_d = probe ? ST_TWO : ST_IDLE;
        ST_TWO: begin
          if (open_hit) begin
            st_d   = ST_IDLE;
            open_d = 1'b1;
          end else begin
            // a stray probe restarts the pattern as step one
            st_d = probe ? ST_ONE : ST_IDLE;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      open_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      open_q <= open_d;
    end
  end

  assign open_o    = open_q;
  assign key_hit_o = open_hit | close_hit;
endmodule

// File: rtl/ata_win_cfg.sv
module ata_win_cfg
  import ata_win_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CFG_W-1:0]  wbyte_i,
  input  logic              strap_i,
  output logic [CFG_W-1:0]  rbyte_o,
  output logic [CFG_W-1:0]  rd_tim_o,
  output logic [CFG_W-1:0]  wr_tim_o,
  output logic              chan_en_o,
  output logic [MISC_W-1:0] misc_o
);
  logic [CFG_W-1:0]  rdt_q, wrt_q;
  logic              en_q;
  logic [MISC_W-1:0] misc_q;
  logic [CFG_W-1:0]  misc_w;

  assign misc_w = wbyte_i & MISC_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdt_q  <= '0;
      wrt_q  <= '0;
      en_q   <= 1'b0;
      misc_q <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        ADDR_W'(OFS_RDT):  rdt_q <= wbyte_i;
        ADDR_W'(OFS_WRT):  wrt_q <= wbyte_i;
        ADDR_W'(OFS_CTL): begin
          if (wbyte_i == CTL_ON)       en_q <= 1'b1;
          else if (wbyte_i == CTL_OFF) en_q <= 1'b0;
        end
        ADDR_W'(OFS_MISC): misc_q <= misc_w[MISC_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_W'(OFS_RDT):   rbyte_o = rdt_q;
      ADDR_W'(OFS_WRT):   rbyte_o = wrt_q;
      ADDR_W'(OFS_CTL):   rbyte_o = en_q ? CTL_ON : CTL_OFF;
      ADDR_W'(OFS_STRAP): rbyte_o = {{(CFG_W-1){1'b0}}, strap_i};
      ADDR_W'(OFS_MISC):  rbyte_o = {{(CFG_W-MISC_W){1'b0}}, misc_q};
      default:            rbyte_o = '0;
    endcase
  end

  assign rd_tim_o  = rdt_q;
  assign wr_tim_o  = wrt_q;
  assign chan_en_o = en_q;
  assign misc_o    = misc_q;
endmodule

// File: rtl/ata_win_shadow.sv
module ata_win_shadow #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              wide_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rword_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int LO_W  = DATA_W / 2;

  logic [DATA_W-1:0] regs_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_q[g] <= '0;
      end else if (we_i && (addr_i == ADDR_W'(g))) begin
        if (wide_i) regs_q[g] <= wdata_i;
        else        regs_q[g][LO_W-1:0] <= wdata_i[LO_W-1:0];
      end
    end
  end

  assign rword_o = regs_q[addr_i];
endmodule

// File: rtl/ata_cfg_window.sv
module ata_cfg_window
  import ata_win_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wide_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              strap_slow_i,
  output logic              win_open_o,
  output logic [CFG_W-1:0]  rd_timing_o,
  output logic [CFG_W-1:0]  wr_timing_o,
  output logic              chan_en_o,
  output logic [MISC_W-1:0] misc_o
);
  localparam int LO_W = DATA_W / 2;

  logic             open_w, key_hit;
  logic             cfg_we, sh_we;
  logic [CFG_W-1:0] cfg_rbyte;
  logic [DATA_W-1:0] sh_word;

  ata_win_unlock #(.ADDR_W(ADDR_W)) i_unlock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_i      (rd_i),
    .wr_i      (wr_i),
    .wide_i    (wide_i),
    .addr_i    (addr_i),
    .wbyte_i   (wdata_i[CFG_W-1:0]),
    .open_o    (open_w),
    .key_hit_o (key_hit)
  );

  assign cfg_we = wr_i && open_w && !wide_i && !key_hit;
  assign sh_we  = wr_i && !open_w && !key_hit;

  ata_win_cfg #(.ADDR_W(ADDR_W)) i_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we),
    .addr_i    (addr_i),
    .wbyte_i   (wdata_i[CFG_W-1:0]),
    .strap_i   (strap_slow_i),
    .rbyte_o   (cfg_rbyte),
    .rd_tim_o  (rd_timing_o),
    .wr_tim_o  (wr_timing_o),
    .chan_en_o (chan_en_o),
    .misc_o    (misc_o)
  );

  ata_win_shadow #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_shadow (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (sh_we),
    .wide_i  (wide_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rword_o (sh_word)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (open_w)      rdata_o = wide_i ? '0 : {{(DATA_W-CFG_W){1'b0}}, cfg_rbyte};
      else if (wide_i) rdata_o = sh_word;
      else             rdata_o = {{(DATA_W-LO_W){1'b0}}, sh_word[LO_W-1:0]};
    end
  end

  assign win_open_o = open_w;
endmodule

// File: rtl/ata_win_chk.sv
module ata_win_chk
  import ata_win_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wide_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              strap_slow_i,
  input logic              win_open_o,
  input logic [CFG_W-1:0]  rd_timing_o,
  input logic [CFG_W-1:0]  wr_timing_o,
  input logic              chan_en_o,
  input logic [MISC_W-1:0] misc_o
);
  // R2
  open_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(win_open_o) |-> $past(wr_i && !wide_i && addr_i == ADDR_W'(OFS_KEY)
                               && wdata_i[CFG_W-1:0] == KEY_OPEN));
  // R6
  close_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(win_open_o) |-> $past(wr_i && !wide_i && addr_i == ADDR_W'(OFS_KEY)
                               && wdata_i[CFG_W-1:0] == KEY_CLOSE));
  // R7
  rd_tim_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rd_timing_o) |-> $past(win_open_o && wr_i && !wide_i
                                    && addr_i == ADDR_W'(OFS_RDT)));
  // R8
  ctl_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(chan_en_o) |-> $past(win_open_o && wr_i && !wide_i && addr_i == ADDR_W'(OFS_CTL)
                                  && (wdata_i[CFG_W-1:0] == CTL_ON || wdata_i[CFG_W-1:0] == CTL_OFF)));
  // R9
  strap_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_open_o && rd_i && !wide_i && addr_i == ADDR_W'(OFS_STRAP))
      |-> rdata_o == {{(DATA_W-1){1'b0}}, strap_slow_i});
  // R10
  misc_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_open_o && rd_i && !wide_i && addr_i == ADDR_W'(OFS_MISC))
      |-> rdata_o[DATA_W-1:MISC_W] == '0);
  // R12
  rd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> rdata_o == '0);
endmodule

bind ata_cfg_window ata_win_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_ata_cfg_window.sv
module test_ata_cfg_window;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  addr_i = '0;
  logic        wide_i = 1'b0;
  logic        rd_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        strap_slow_i = 1'b0;
  logic        win_open_o;
  logic [7:0]  rd_timing_o, wr_timing_o;
  logic        chan_en_o;
  logic [6:0]  misc_o;

  int total = 0;
  int bad = 0;
  logic done = 1'b0;

  always #10 clk_i = ~clk_i;

  ata_cfg_window i_ata_cfg_window (.*);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic r, input logic w, input logic wd, input logic [2:0] a,
                     input logic [15:0] d, output logic [15:0] q);
    @(negedge clk_i);
    rd_i = r; wr_i = w; wide_i = wd; addr_i = a; wdata_i = d;
    #5 q = rdata_o;
    @(posedge clk_i);
    #1 rd_i = 1'b0; wr_i = 1'b0;
  endtask

  task automatic rd16(input logic [2:0] a, output logic [15:0] q);
    acc(1'b1, 1'b0, 1'b1, a, 16'h0, q);
  endtask
  task automatic rd8(input logic [2:0] a, output logic [15:0] q);
    acc(1'b1, 1'b0, 1'b0, a, 16'h0, q);
  endtask
  task automatic wr16(input logic [2:0] a, input logic [15:0] d);
    logic [15:0] q;
    acc(1'b0, 1'b1, 1'b1, a, d, q);
  endtask
  task automatic wr8(input logic [2:0] a, input logic [7:0] d);
    logic [15:0] q;
    acc(1'b0, 1'b1, 1'b0, a, {8'hA5, d}, q);
  endtask
  task automatic gap(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic t_reset();
    chk("R1 win_open", 16'(win_open_o), 16'h0);
    chk("R1 chan_en", 16'(chan_en_o), 16'h0);
    chk("R1 rd_timing", 16'(rd_timing_o), 16'h0);
    chk("R1 wr_timing", 16'(wr_timing_o), 16'h0);
    chk("R1 misc", 16'(misc_o), 16'h0);
    chk("R12 idle rdata", rdata_o, 16'h0);
  endtask

  task automatic t_passthrough();
    logic [15:0] q;
    wr16(3'd0, 16'hBEEF);
    rd16(3'd0, q); chk("R11 wide read", q, 16'hBEEF);
    rd8(3'd0, q);  chk("R11 byte read", q, 16'h00EF);
    wr8(3'd0, 8'h12);
    rd16(3'd0, q); chk("R11 byte write keeps high", q, 16'hBE12);
    wr8(3'd4, 8'h5A);
    rd8(3'd4, q);  chk("R11 byte write low", q, 16'h005A);
  endtask

  task automatic t_unlock();
    logic [15:0] q;
    wr8(3'd1, 8'h77);
    rd16(3'd1, q); chk("R4 first key read data", q, 16'h0077);
    gap(2);
    rd16(3'd1, q); chk("R4 second key read data", q, 16'h0077);
    chk("R2 not yet open", 16'(win_open_o), 16'h0);
    wr8(3'd2, 8'h03);
    chk("R2 window opens", 16'(win_open_o), 16'h1);
    rd16(3'd0, q); chk("R5 wide read in window", q, 16'h0);
  endtask

  task automatic t_timing();
    logic [15:0] q;
    wr8(3'd0, 8'h5A);
    chk("R7 rd_timing out", 16'(rd_timing_o), 16'h005A);
    rd8(3'd0, q); chk("R7 rd_timing read", q, 16'h005A);
    wr8(3'd1, 8'h31);
    chk("R7 wr_timing out", 16'(wr_timing_o), 16'h0031);
    rd8(3'd1, q); chk("R5 offset1 maps to config", q, 16'h0031);
    wr16(3'd0, 16'hFFFF);
    chk("R5 wide write ignored", 16'(rd_timing_o), 16'h005A);
  endtask

  task automatic t_control();
    logic [15:0] q;
    rd8(3'd3, q); chk("R8 ctl reads off", q, 16'h0011);
    wr8(3'd3, 8'h95);
    chk("R8 enable", 16'(chan_en_o), 16'h1);
    rd8(3'd3, q); chk("R8 ctl reads on", q, 16'h0095);
    wr8(3'd3, 8'h42);
    chk("R8 other value ignored", 16'(chan_en_o), 16'h1);
    wr8(3'd3, 8'h11);
    chk("R8 disable", 16'(chan_en_o), 16'h0);
  endtask

  task automatic t_strap();
    logic [15:0] q;
    strap_slow_i = 1'b1;
    rd8(3'd5, q); chk("R9 strap 25MHz", q, 16'h0001);
    wr8(3'd5, 8'hFE);
    rd8(3'd5, q); chk("R9 strap write no effect", q, 16'h0001);
    strap_slow_i = 1'b0;
    rd8(3'd5, q); chk("R9 strap 33MHz", q, 16'h0000);
  endtask

  task automatic t_misc();
    logic [15:0] q;
    wr8(3'd6, 8'hFF);
    chk("R10 misc out masked", 16'(misc_o), 16'h007F);
    rd8(3'd6, q); chk("R10 misc read", q, 16'h007F);
  endtask

  task automatic t_close();
    logic [15:0] q;
    wr8(3'd2, 8'h55);
    chk("R6 other value keeps open", 16'(win_open_o), 16'h1);
    wr8(3'd2, 8'h83);
    chk("R6 window closes", 16'(win_open_o), 16'h0);
    rd16(3'd1, q); chk("R5 task file untouched", q, 16'h0077);
    rd8(3'd2, q);  chk("R4 key writes absorbed", q, 16'h0000);
    chk("R7 rd_timing kept", 16'(rd_timing_o), 16'h005A);
  endtask

  task automatic t_mismatch();
    logic [15:0] q;
    rd16(3'd1, q); rd16(3'd1, q); rd16(3'd1, q);
    wr8(3'd2, 8'h03);
    chk("R3 three reads then key stays shut", 16'(win_open_o), 16'h0);
    rd8(3'd2, q); chk("R3 mismatched write reaches task file", q, 16'h0003);
    rd16(3'd1, q); rd8(3'd1, q); rd16(3'd1, q);
    wr8(3'd2, 8'h03);
    chk("R3 byte read breaks pattern", 16'(win_open_o), 16'h0);
    rd16(3'd1, q); rd16(3'd1, q); rd16(3'd1, q); rd16(3'd1, q);
    wr8(3'd2, 8'h03);
    chk("R3 stray probe restarts as step one", 16'(win_open_o), 16'h1);
    wr8(3'd2, 8'h83);
    chk("R6 close again", 16'(win_open_o), 16'h0);
  endtask

  initial begin
    #15000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #35 rst_ni = 1'b1;
    gap(1);
    t_reset();
    t_passthrough();
    t_unlock();
    t_timing();
    t_control();
    t_strap();
    t_misc();
    t_close();
    t_mismatch();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule